// File: doc/BRIEF.md
# SMBus Host Register Front-End

This block is the byte-wide register file that software sees on a PC-style SMBus host controller. It decodes a small I/O window into eight registers: status, control, command, target address, two data bytes, a block-data byte and an auxiliary control byte. The status bits are cleared by writing ones to them. Writing the control register can start or kill a transaction. A level interrupt follows the status bits.

The block does not drive the serial wire and does not hold the block buffer. When a transaction starts, it raises a one-cycle launch strobe toward a separate transaction engine. That engine reports completion, device errors, bus errors and alerts back on single-cycle inputs. A one-cycle index-clear strobe tells the block buffer to rewind.

A start written while the interrupt enable is low is not issued at once. Instead the busy bit is set and the start is held pending. The pending start is issued when software next reads the status register. That read still returns the status as it was, busy included.

Top module: `smb_host_regs`

## Requirements
- R1: The registers sit at these offsets: status 0x00, control 0x02, command 0x03, target address 0x04, data byte 0 at 0x05, data byte 1 at 0x06, block data 0x07, aux control 0x0D. The command, address, data and block-data registers read back what was written and drive the matching engine outputs. A read of any other offset returns 0x00.
- R2: The status bits are busy (0), done interrupt (1), device error (2), bus error (3), failed (4), alert (5), in-use (6) and byte-done (7). Writing the status register clears each bit written as 1. Busy is never cleared by such a write.
- R3: The control register holds interrupt enable (0), kill (1), protocol code (4:2), last-byte (5), start (6) and PEC enable (7). A read of control returns only bits 4:0, so start always reads 0. The stored protocol code, last-byte and PEC bits drive proto_o, last_byte_o and pec_en_o.
- R4: A control write with start=1, kill=0 and interrupt enable=1 pulses launch_o for one cycle after the write and drives op_idle_o low. Busy is not set.
- R5: A control write with start=1, kill=0 and interrupt enable=0 sets busy and does not launch. The next status read returns the status with busy still set. launch_o pulses after that read, busy clears and op_idle_o goes low.
- R6: A control write with kill=1 sets failed, clears busy, cancels a pending deferred start, pulses idx_clr_o and drives op_idle_o high.
- R7: irq_o is high exactly when interrupt enable is 1 and any status bit from 7 down to 1 is set. Busy alone never raises it.
- R8: Aux control keeps only bits 1:0 (PEC at bit 0, block-buffer mode at bit 1). Reset sets bit 1 to the FORCE_BLK parameter and bit 0 to 0.
- R9: After reset the status reads 0x00, op_idle_o is 1, irq_o is 0, and the other registers read 0x00.
- R10: eng_done_i sets bit 1 and clears busy. eng_dev_err_i sets bit 2 and clears busy. Both return op_idle_o high. eng_bus_err_i sets bit 3 and alert_i sets bit 5. An engine report wins over a status clear written in the same cycle.
- R11: A start written while op_idle_o is low pulses idx_clr_o, aborting the operation in progress before the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while bus_rd is high |
| irq_o | output | 1 | Level interrupt |
| launch_o | output | 1 | One-cycle transaction start to the engine |
| idx_clr_o | output | 1 | One-cycle block index rewind |
| op_idle_o | output | 1 | No operation in progress |
| proto_o | output | 3 | Protocol code |
| last_byte_o | output | 1 | Last-byte control bit |
| pec_en_o | output | 1 | PEC enable control bit |
| cmd_o | output | 8 | Command byte |
| taddr_o | output | 8 | Target address byte (bit 0 read/write) |
| data0_o | output | 8 | Data byte 0 |
| data1_o | output | 8 | Data byte 1 |
| blkdat_o | output | 8 | Block data byte |
| aux_o | output | 2 | Aux control bits |
| eng_done_i | input | 1 | Engine completion pulse |
| eng_dev_err_i | input | 1 | Engine device error pulse |
| eng_bus_err_i | input | 1 | Engine bus error pulse |
| alert_i | input | 1 | Alert pulse |

## Verification
bus_rdata is combinational from the registers and the strobe, so the bench samples it in the same cycle as the read, before the edge that accepts it. Register updates, launch_o, idx_clr_o, op_idle_o and irq_o all change at the edge that accepts a strobe or an engine pulse. They are checked at the falling edge that follows, which is one register stage after the stimulus. The launch pulse is also checked to be gone one cycle later. The deferred start is checked in three steps: the read that triggers it, the cycle after that read, and a second status read.

// File: rtl/smb_host_pkg.sv
// Shared constants for the SMBus host register front-end.
// Assumes byte-wide registers; offsets are the decode contract with software.
package smb_host_pkg;
    localparam int NREG = 8;
    // register indices (one-hot position in the decode vectors)
    localparam int IX_STS = 0;
    localparam int IX_CTL = 1;
    localparam int IX_CMD = 2;
    localparam int IX_ADR = 3;
    localparam int IX_D0  = 4;
    localparam int IX_D1  = 5;
    localparam int IX_BLK = 6;
    localparam int IX_AUX = 7;
    // status bit positions
    localparam int SB_BUSY   = 0;
    localparam int SB_INTR   = 1;
    localparam int SB_DEVERR = 2;
    localparam int SB_BUSERR = 3;
    localparam int SB_FAILED = 4;
    localparam int SB_ALERT  = 5;
    // control bit positions
    localparam int CB_IEN   = 0;
    localparam int CB_KILL  = 1;
    localparam int CB_LAST  = 5;
    localparam int CB_START = 6;
    localparam int CB_PEC   = 7;

    // byte offset of register index ix
    function automatic int reg_ofs(input int ix);
        case (ix)
            IX_STS:  return 0;
            IX_CTL:  return 2;
            IX_CMD:  return 3;
            IX_ADR:  return 4;
            IX_D0:   return 5;
            IX_D1:   return 6;
            IX_BLK:  return 7;
            default: return 13;
        endcase
    endfunction
endpackage

// File: rtl/smb_reg_decode.sv
// Address decoder: turns the byte offset and strobes into one-hot
// per-register hit, write-select and read-select vectors.
// Assumes at most one of wr/rd is high in a cycle.
module smb_reg_decode
    import smb_host_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    output logic [NREG-1:0]   hit,
    output logic [NREG-1:0]   wr_sel,
    output logic [NREG-1:0]   rd_sel
);
    // one comparator per register
    for (genvar g = 0; g < NREG; g++) begin : g_dec
        localparam logic [ADDR_W-1:0] OFS = ADDR_W'(reg_ofs(g));
        assign hit[g] = (addr == OFS);
    end

    assign wr_sel = hit & {NREG{wr}};
    assign rd_sel = hit & {NREG{rd}};
endmodule

// File: rtl/smb_cfg_regs.sv
// Plain configuration registers: control, command, address, two data
// bytes, block data and aux control. No side effects live here.
// Assumes wr_sel is one-hot or zero.
module smb_cfg_regs
    import smb_host_pkg::*;
#(
    parameter bit FORCE_BLK = 1'b0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NREG-1:0] wr_sel,
    input  logic [7:0]      wdata,
    output logic [7:0]      ctl_q,
    output logic [7:0]      cmd_q,
    output logic [7:0]      adr_q,
    output logic [7:0]      d0_q,
    output logic [7:0]      d1_q,
    output logic [7:0]      blk_q,
    output logic [1:0]      aux_q
);
    localparam logic [7:0] CTL_KEEP = ~(8'd1 << CB_START);
    localparam logic [1:0] AUX_RST  = {FORCE_BLK, 1'b0};

    // control keeps everything but the self-clearing start bit
    always_ff @(posedge clk) begin
        if (!rst_n)                ctl_q <= 8'h00;
        else if (wr_sel[IX_CTL])   ctl_q <= wdata & CTL_KEEP;
    end

    // byte registers handed straight to the engine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= 8'h00;
            adr_q <= 8'h00;
            d0_q  <= 8'h00;
            d1_q  <= 8'h00;
            blk_q <= 8'h00;
        end else begin
            if (wr_sel[IX_CMD]) cmd_q <= wdata;
            if (wr_sel[IX_ADR]) adr_q <= wdata;
            if (wr_sel[IX_D0])  d0_q  <= wdata;
            if (wr_sel[IX_D1])  d1_q  <= wdata;
            if (wr_sel[IX_BLK]) blk_q <= wdata;
        end
    end

    // aux control keeps its two low bits only
    always_ff @(posedge clk) begin
        if (!rst_n)              aux_q <= AUX_RST;
        else if (wr_sel[IX_AUX]) aux_q <= wdata[1:0];
    end
endmodule

// File: rtl/smb_status_ctl.sv
// Status register and transaction sequencing: write-one-to-clear, start
// (immediate or deferred to the next status read), kill, engine reports.
// Assumes engine report pulses are one cycle long; reports win over a
// same-cycle software clear.
module smb_status_ctl
    import smb_host_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_sts,
    input  logic       rd_sts,
    input  logic       wr_ctl,
    input  logic [7:0] wdata,
    input  logic       eng_done,
    input  logic       eng_dev_err,
    input  logic       eng_bus_err,
    input  logic       alert,
    output logic [7:0] stat_q,
    output logic       pending_q,
    output logic       op_idle_q,
    output logic       launch_q,
    output logic       idx_clr_q
);
    localparam logic [7:0] SW_CLR_MASK = ~(8'd1 << SB_BUSY);

    logic [7:0] stat_n;
    logic       pend_n, idle_n, launch_n, idxclr_n;
    logic       start_w, kill_w;

    assign start_w = wr_ctl & wdata[CB_START];
    assign kill_w  = wr_ctl & wdata[CB_KILL];

    // next-state for status and sequencing flags, lowest priority first
    always_comb begin
        stat_n   = stat_q;
        pend_n   = pending_q;
        idle_n   = op_idle_q;
        launch_n = 1'b0;
        idxclr_n = 1'b0;
        if (wr_sts) stat_n = stat_q & ~(wdata & SW_CLR_MASK);
        if (rd_sts && pending_q) begin
            pend_n           = 1'b0;
            stat_n[SB_BUSY]  = 1'b0;
            launch_n         = 1'b1;
            idle_n           = 1'b0;
        end
        if (start_w) begin
            if (!op_idle_q) idxclr_n = 1'b1;
            if (wdata[CB_IEN]) begin
                launch_n = 1'b1;
                idle_n   = 1'b0;
                pend_n   = 1'b0;
            end else begin
                stat_n[SB_BUSY] = 1'b1;
                pend_n          = 1'b1;
                idle_n          = 1'b1;
            end
        end
        if (kill_w) begin
            launch_n          = 1'b0;
            idle_n            = 1'b1;
            idxclr_n          = 1'b1;
            pend_n            = 1'b0;
            stat_n[SB_FAILED] = 1'b1;
            stat_n[SB_BUSY]   = 1'b0;
        end
        if (eng_done) begin
            stat_n[SB_INTR] = 1'b1;
            stat_n[SB_BUSY] = 1'b0;
            idle_n          = 1'b1;
        end
        if (eng_dev_err) begin
            stat_n[SB_DEVERR] = 1'b1;
            stat_n[SB_BUSY]   = 1'b0;
            idle_n            = 1'b1;
        end
        if (eng_bus_err) stat_n[SB_BUSERR] = 1'b1;
        if (alert)       stat_n[SB_ALERT]  = 1'b1;
    end

    // state registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q    <= 8'h00;
            pending_q <= 1'b0;
            op_idle_q <= 1'b1;
            launch_q  <= 1'b0;
            idx_clr_q <= 1'b0;
        end else begin
            stat_q    <= stat_n;
            pending_q <= pend_n;
            op_idle_q <= idle_n;
            launch_q  <= launch_n;
            idx_clr_q <= idxclr_n;
        end
    end
endmodule

// File: rtl/smb_host_regs.sv
// Top of the SMBus host register front-end: decode, configuration
// registers, status sequencing, read mux and level interrupt.
// Assumes a single-cycle byte port; side effects occur at the accepting edge.
module smb_host_regs
    import smb_host_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter bit FORCE_BLK = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              irq_o,
    output logic              launch_o,
    output logic              idx_clr_o,
    output logic              op_idle_o,
    output logic [2:0]        proto_o,
    output logic              last_byte_o,
    output logic              pec_en_o,
    output logic [7:0]        cmd_o,
    output logic [7:0]        taddr_o,
    output logic [7:0]        data0_o,
    output logic [7:0]        data1_o,
    output logic [7:0]        blkdat_o,
    output logic [1:0]        aux_o,
    input  logic              eng_done_i,
    input  logic              eng_dev_err_i,
    input  logic              eng_bus_err_i,
    input  logic              alert_i
);
    logic [NREG-1:0] hit, wr_sel, rd_sel;
    logic [7:0]      ctl_q, stat_q;
    logic            pending_q;

    smb_reg_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
        .hit(hit), .wr_sel(wr_sel), .rd_sel(rd_sel)
    );

    smb_cfg_regs #(.FORCE_BLK(FORCE_BLK)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_sel(wr_sel), .wdata(bus_wdata),
        .ctl_q(ctl_q), .cmd_q(cmd_o), .adr_q(taddr_o), .d0_q(data0_o),
        .d1_q(data1_o), .blk_q(blkdat_o), .aux_q(aux_o)
    );

    smb_status_ctl u_sts (
        .clk(clk), .rst_n(rst_n),
        .wr_sts(wr_sel[IX_STS]), .rd_sts(rd_sel[IX_STS]),
        .wr_ctl(wr_sel[IX_CTL]), .wdata(bus_wdata),
        .eng_done(eng_done_i), .eng_dev_err(eng_dev_err_i),
        .eng_bus_err(eng_bus_err_i), .alert(alert_i),
        .stat_q(stat_q), .pending_q(pending_q), .op_idle_q(op_idle_o),
        .launch_q(launch_o), .idx_clr_q(idx_clr_o)
    );

    // read mux; unmapped offsets and idle cycles return zero
    always_comb begin
        bus_rdata = 8'h00;
        if (bus_rd) begin
            unique case (1'b1)
                hit[IX_STS]: bus_rdata = stat_q;
                hit[IX_CTL]: bus_rdata = {3'b000, ctl_q[4:0]};
                hit[IX_CMD]: bus_rdata = cmd_o;
                hit[IX_ADR]: bus_rdata = taddr_o;
                hit[IX_D0]:  bus_rdata = data0_o;
                hit[IX_D1]:  bus_rdata = data1_o;
                hit[IX_BLK]: bus_rdata = blkdat_o;
                hit[IX_AUX]: bus_rdata = {6'd0, aux_o};
                default:     bus_rdata = 8'h00;
            endcase
        end
    end

    // engine-facing control fields
    assign proto_o     = ctl_q[4:2];
    assign last_byte_o = ctl_q[CB_LAST];
    assign pec_en_o    = ctl_q[CB_PEC];

    // level interrupt ignores busy, gated by enable
    assign irq_o = ctl_q[CB_IEN] & (|stat_q[7:1]);
endmodule

// File: rtl/smb_host_regs_chk.sv
// Assertion checker for smb_host_regs, attached by bind.
module smb_host_regs_chk #(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [7:0]        bus_wdata,
    input logic              irq_o,
    input logic              launch_o,
    input logic              idx_clr_o,
    input logic              op_idle_o,
    input logic              eng_done_i,
    input logic [7:0]        stat_q,
    input logic [7:0]        ctl_q
);
    localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(2);

    // R4
    imm_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_CTL && bus_wdata[6] && bus_wdata[0] && !bus_wdata[1])
        |=> launch_o);

    // R6
    kill_rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_CTL && bus_wdata[1]) |=> (idx_clr_o && op_idle_o && !launch_o));

    // R5
    busy_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_q[0]) |-> ($past(bus_wr) && $past(bus_addr) == A_CTL));

    // R10
    done_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done_i |=> (stat_q[1] && !stat_q[0] && op_idle_o));

    // R7
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (ctl_q[0] && stat_q[7:1] != 7'd0));
endmodule

bind smb_host_regs smb_host_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .irq_o(irq_o), .launch_o(launch_o),
    .idx_clr_o(idx_clr_o), .op_idle_o(op_idle_o), .eng_done_i(eng_done_i),
    .stat_q(stat_q), .ctl_q(ctl_q)
);

// File: tb/tb_smb_host_regs.sv
module tb_smb_host_regs;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic irq_o, launch_o, idx_clr_o, op_idle_o, last_byte_o, pec_en_o;
    logic [2:0] proto_o;
    logic [7:0] cmd_o, taddr_o, data0_o, data1_o, blkdat_o;
    logic [1:0] aux_o;
    logic eng_done_i = 0, eng_dev_err_i = 0, eng_bus_err_i = 0, alert_i = 0;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    smb_host_regs #(.ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .launch_o(launch_o), .idx_clr_o(idx_clr_o),
        .op_idle_o(op_idle_o), .proto_o(proto_o), .last_byte_o(last_byte_o),
        .pec_en_o(pec_en_o), .cmd_o(cmd_o), .taddr_o(taddr_o),
        .data0_o(data0_o), .data1_o(data1_o), .blkdat_o(blkdat_o),
        .aux_o(aux_o), .eng_done_i(eng_done_i), .eng_dev_err_i(eng_dev_err_i),
        .eng_bus_err_i(eng_bus_err_i), .alert_i(alert_i)
    );

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // write one register; returns at the falling edge after the accepting edge
    task automatic wr(input int a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = AW'(a); bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // read one register; data sampled before the accepting edge
    task automatic rd(input int a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = AW'(a); bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // engine report pulse, optionally with a same-cycle status clear
    task automatic eng(input logic dn, de, be, al, input logic clr, input logic [7:0] cv);
        @(negedge clk);
        eng_done_i = dn; eng_dev_err_i = de; eng_bus_err_i = be; alert_i = al;
        if (clr) begin bus_addr = '0; bus_wdata = cv; bus_wr = 1'b1; end
        @(negedge clk);
        eng_done_i = 0; eng_dev_err_i = 0; eng_bus_err_i = 0; alert_i = 0; bus_wr = 1'b0;
    endtask

    function automatic logic [7:0] model_stat(input logic [7:0] s, input logic clr,
        input logic [7:0] cv, input logic dn, de, be, al);
        logic [7:0] r;
        r = clr ? (s & ~(cv & 8'hFE)) : s;
        if (dn) begin r[1] = 1'b1; r[0] = 1'b0; end
        if (de) begin r[2] = 1'b1; r[0] = 1'b0; end
        if (be) r[3] = 1'b1;
        if (al) r[5] = 1'b1;
        return r;
    endfunction

    function automatic logic model_irq(input logic [7:0] s, input logic [7:0] c);
        return c[0] && (s[7:1] != 7'd0);
    endfunction

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic [7:0] m_stat, m_ctl;
        logic [7:0] m_reg [8];
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R9 reset state
        rd(0, v); check("R9 status", v, 8'h00);
        check("R9 idle", op_idle_o, 1);
        check("R9 irq", irq_o, 0);
        rd(3, v); check("R9 cmd", v, 8'h00);
        rd(13, v); check("R8 aux reset", v, 8'h00);

        // R1 readback and unmapped
        wr(3, 8'hA5); wr(4, 8'h3C); wr(5, 8'h11); wr(6, 8'h22); wr(7, 8'h33);
        rd(3, v); check("R1 cmd", v, 8'hA5);
        rd(4, v); check("R1 addr", v, 8'h3C);
        rd(5, v); check("R1 d0", v, 8'h11);
        rd(6, v); check("R1 d1", v, 8'h22);
        rd(7, v); check("R1 blk", v, 8'h33);
        check("R1 taddr_o", taddr_o, 8'h3C);
        rd(1, v); check("R1 unmapped 1", v, 8'h00);
        rd(63, v); check("R1 unmapped 63", v, 8'h00);

        // R8 aux keeps two bits
        wr(13, 8'hFF); rd(13, v); check("R8 aux", v, 8'h03);
        check("R8 aux_o", aux_o, 2'b11);

        // R3 control fields and readback
        wr(2, 8'hBC); rd(2, v); check("R3 ctl readback", v, 8'h1C);
        check("R3 proto", proto_o, 3'd7);
        check("R3 last", last_byte_o, 1);
        check("R3 pec", pec_en_o, 1);
        wr(2, 8'h00);

        // R5 deferred start
        wr(2, 8'h48);
        check("R5 no launch", launch_o, 0);
        check("R3 proto after start", proto_o, 3'd2);
        check("R7 busy only", irq_o, 0);
        rd(0, v); check("R5 old status", v, 8'h01);
        check("R5 launch", launch_o, 1);
        check("R5 busy", op_idle_o, 0);
        rd(0, v); check("R5 busy cleared", v, 8'h00);
        check("R5 single pulse", launch_o, 0);

        // R10 done report and R7 interrupt
        eng(1, 0, 0, 0, 0, 8'h00);
        rd(0, v); check("R10 done", v, 8'h02);
        check("R10 idle", op_idle_o, 1);
        check("R7 irq gated", irq_o, 0);
        wr(2, 8'h01); check("R7 irq on", irq_o, 1);
        wr(0, 8'h02); check("R7 irq off", irq_o, 0);
        rd(0, v); check("R2 w1c", v, 8'h00);

        // R4 immediate start, R11 restart while active
        wr(2, 8'h41);
        check("R4 launch", launch_o, 1);
        check("R4 active", op_idle_o, 0);
        check("R4 no rewind", idx_clr_o, 0);
        rd(0, v); check("R4 no busy", v, 8'h00);
        rd(2, v); check("R3 start reads 0", v, 8'h01);
        wr(2, 8'h41);
        check("R11 rewind", idx_clr_o, 1);
        check("R11 relaunch", launch_o, 1);

        // R6 kill
        wr(2, 8'h02);
        check("R6 rewind", idx_clr_o, 1);
        check("R6 idle", op_idle_o, 1);
        check("R6 no launch", launch_o, 0);
        rd(0, v); check("R6 failed", v, 8'h10);
        wr(2, 8'h40); wr(2, 8'h02);
        rd(0, v); check("R6 busy cleared", v, 8'h10);
        check("R6 pending cancelled", launch_o, 0);

        // R2 busy not software-clearable; R7 busy alone with enable
        wr(0, 8'hFF);
        wr(2, 8'h40); wr(2, 8'h01);
        check("R7 busy alone", irq_o, 0);
        wr(0, 8'hFF);
        rd(0, v); check("R2 busy kept", v, 8'h01);
        check("R5 launch after read", launch_o, 1);

        // R10 report wins over same-cycle clear; other report bits
        eng(1, 0, 0, 0, 1, 8'h02);
        rd(0, v); check("R10 set wins", v, 8'h02);
        eng(0, 1, 1, 1, 0, 8'h00);
        rd(0, v); check("R10 err bits", v, 8'h2E);
        check("R7 irq err", irq_o, 1);
        wr(0, 8'hFF); wr(2, 8'h00);

        // random mix checked against bench model
        m_stat = 8'h00; m_ctl = 8'h00;
        for (int k = 0; k < 8; k++) m_reg[k] = 8'h00;
        m_reg[3] = 8'hA5; m_reg[4] = 8'h3C; m_reg[5] = 8'h11; m_reg[6] = 8'h22; m_reg[7] = 8'h33;
        for (int it = 0; it < 300; it++) begin
            int op;
            op = int'($urandom % 4);
            if (op == 0) begin
                int a;
                a = 3 + int'($urandom % 5);
                m_reg[a] = 8'($urandom);
                wr(a, m_reg[a]);
                rd(a, v); check("R1 random readback", v, m_reg[a]);
            end else if (op == 1) begin
                m_ctl = 8'($urandom) & 8'hBD;
                wr(2, m_ctl);
                rd(2, v); check("R3 random ctl", v, {3'b000, m_ctl[4:0]});
                check("R7 random irq", irq_o, model_irq(m_stat, m_ctl));
            end else if (op == 2) begin
                logic dn, de, be, al, cl;
                logic [7:0] cv;
                dn = 1'($urandom); de = 1'($urandom); be = 1'($urandom);
                al = 1'($urandom); cl = 1'($urandom); cv = 8'($urandom);
                eng(dn, de, be, al, cl, cv);
                m_stat = model_stat(m_stat, cl, cv, dn, de, be, al);
                check("R10 random irq", irq_o, model_irq(m_stat, m_ctl));
            end else begin
                logic [7:0] cv;
                cv = 8'($urandom);
                wr(0, cv);
                m_stat = model_stat(m_stat, 1'b1, cv, 0, 0, 0, 0);
                rd(0, v); check("R2 random status", v, m_stat);
                check("R7 random irq", irq_o, model_irq(m_stat, m_ctl));
            end
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule